// File: doc/BRIEF.md
# Twelve-Hour Alarm Clock Core

This block keeps the time of day in twelve-hour form. It counts hours from 0 to 11, minutes and seconds from 0 to 59, and holds a morning/afternoon flag. A one-cycle pulse arrives once per second from an external divider and advances the count. One alarm setting is held, made up of an hour, a minute and a morning/afternoon flag. When the running time reaches that setting at second zero, an alarm line is raised for a fixed number of seconds.

After reset the block walks through two setup phases in a fixed order. The alarm is entered first and the current time second. In each phase, two active-low push-buttons step the hour and the minute, and a level switch picks morning or afternoon. A start input moves the block from one phase to the next, and finally into running. The block presents the digits as BCD pairs, together with a phase code, so that a separate display driver can show the right prompt and values.

Top module: `alarm_clock12_core`

## Requirements
- R1: In the run phase each `sec_tick` pulse advances the seconds. Seconds wrap from 59 to 0 and carry one into the minutes. Minutes wrap from 59 to 0 and carry one into the hours.
- R2: Hours count 0 to 11. A tick at 11:59:59 returns all three counters to 0 and inverts `pm_flag`.
- R3: After reset, `phase` reads 0 (alarm entry). The first rising edge on `start` moves it to 1 (time entry). The second moves it to 2 (run). Phase 2 holds until reset. At reset the time and the alarm are both 00:00:00 in the morning.
- R4: In phases 0 and 1, each high-to-low transition of `hr_btn_n` or `mn_btn_n` steps the hour or the minute of the value being entered by exactly one. Phase 0 edits the alarm and phase 1 edits the time. Holding a button low gives one step only. Hours wrap 11 to 0 and minutes wrap 59 to 0, with no carry between them.
- R5: `ampm_sel` low means morning and high means afternoon. In a setup phase, the value being entered follows this level. In phase 2, `ampm_sel`, both buttons and `start` have no effect.
- R6: Before phase 2, ticks leave the time unchanged and the seconds stay at 0.
- R7: `alarm_out` rises when a tick brings the time to the alarm's hour, minute and morning/afternoon flag with seconds at 0. It rises one clock after the displayed time changes.
- R8: `alarm_out` stays high until `ALARM_SECS` further ticks have arrived (10 by default). It falls one clock after the last of them. It can only be raised again by a new match.
- R9: In phase 0 the digit outputs show the alarm, with seconds shown as 00. In phases 1 and 2 they show the time. Each pair carries the tens digit in bits 7:4 and the units digit in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| hr_btn_n | input | 1 | Hour step button, active low |
| mn_btn_n | input | 1 | Minute step button, active low |
| ampm_sel | input | 1 | Morning (0) / afternoon (1) level switch |
| start | input | 1 | Phase advance; a rising edge is acted on |
| phase | output | 2 | 0 alarm entry, 1 time entry, 2 run |
| hr_bcd | output | 8 | Hour digits, BCD |
| mn_bcd | output | 8 | Minute digits, BCD |
| sc_bcd | output | 8 | Second digits, BCD |
| pm_flag | output | 1 | Afternoon flag of the value shown |
| alarm_out | output | 1 | Alarm drive and alarm-active status |

## Verification
Several properties are checked on every cycle:
- the seconds step and the 11:59:59 wrap with the flag inversion;
- the time standing still outside the run and entry phases;
- the phase never leaving run;
- every rise and fall of the alarm lining up with a one-second strobe, with a rise only at second zero.

Other behaviour only the bench's scenarios can show. This covers the one-step-per-press rule under a held button, the field wraps during entry, inputs being ignored in run, and the exact ten-second length of the alarm. The bench shows these by comparing every output against a behavioural model across a full setup and more than an hour of run time.

// File: rtl/ac12_pkg.sv
package ac12_pkg;

  typedef enum logic [1:0] {
    PH_ALARM = 2'd0,
    PH_TIME  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // step a field, returning to zero after the limit
  function automatic logic [5:0] wrap_inc(input logic [5:0] v, input logic [5:0] lim);
    return (v == lim) ? 6'd0 : v + 6'd1;
  endfunction

  // binary 0..63 to two BCD digits
  function automatic logic [7:0] bin2bcd(input logic [5:0] v);
    int unsigned q;
    int unsigned r;
    q = int'(v) / 10;
    r = int'(v) - q * 10;
    return {q[3:0], r[3:0]};
  endfunction

endpackage

// File: rtl/ac12_sync_edge.sv
module ac12_sync_edge #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   IDLE    = '1,
  parameter logic [W-1:0]   ACT_LOW = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] pulse
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= IDLE[g];
        s2_q   <= IDLE[g];
        prev_q <= IDLE[g];
      end else begin
        s1_q   <= din[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    if (ACT_LOW[g]) begin : g_fall
      assign pulse[g] = prev_q & ~s2_q;
    end else begin : g_rise
      assign pulse[g] = ~prev_q & s2_q;
    end
  end

endmodule

// File: rtl/ac12_timekeeper.sv
module ac12_timekeeper
  import ac12_pkg::*;
#(
  parameter int HW     = 4,
  parameter int MW     = 6,
  parameter int HR_MAX = 11,
  parameter int MN_MAX = 59,
  parameter int SC_MAX = 59
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          set_en,
  input  logic          tick,
  input  logic          hr_inc,
  input  logic          mn_inc,
  input  logic          pm_in,
  output logic [HW-1:0] hr,
  output logic [MW-1:0] mn,
  output logic [MW-1:0] sc,
  output logic          pm
);

  logic [HW-1:0] hr_q, hr_d;
  logic [MW-1:0] mn_q, mn_d, sc_q, sc_d;
  logic          pm_q, pm_d;
  logic          sc_top, mn_top, hr_top;

  assign sc_top = (sc_q == MW'(SC_MAX));
  assign mn_top = (mn_q == MW'(MN_MAX));
  assign hr_top = (hr_q == HW'(HR_MAX));

  always_comb begin
    hr_d = hr_q;
    mn_d = mn_q;
    sc_d = sc_q;
    pm_d = pm_q;
    if (set_en) begin
      if (hr_inc) hr_d = HW'(wrap_inc(6'(hr_q), 6'(HR_MAX)));
      if (mn_inc) mn_d = MW'(wrap_inc(6'(mn_q), 6'(MN_MAX)));
      pm_d = pm_in;
    end else if (run && tick) begin
      sc_d = MW'(wrap_inc(6'(sc_q), 6'(SC_MAX)));
      if (sc_top) begin
        mn_d = MW'(wrap_inc(6'(mn_q), 6'(MN_MAX)));
        if (mn_top) begin
          hr_d = HW'(wrap_inc(6'(hr_q), 6'(HR_MAX)));
          if (hr_top) pm_d = ~pm_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr_q <= '0;
      mn_q <= '0;
      sc_q <= '0;
      pm_q <= 1'b0;
    end else begin
      hr_q <= hr_d;
      mn_q <= mn_d;
      sc_q <= sc_d;
      pm_q <= pm_d;
    end
  end

  assign hr = hr_q;
  assign mn = mn_q;
  assign sc = sc_q;
  assign pm = pm_q;

  a_r1_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !sc_top) |=> (int'(sc_q) == int'($past(sc_q)) + 1));

  a_r2_midday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && sc_top && mn_top && hr_top) |=>
      (hr_q == '0 && mn_q == '0 && sc_q == '0 && pm_q != $past(pm_q)));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !set_en) |=> ($stable(hr_q) && $stable(mn_q) && $stable(sc_q) && $stable(pm_q)));

  a_r6_no_seconds_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sc_q == '0));

endmodule

// File: rtl/ac12_alarm_unit.sv
module ac12_alarm_unit
  import ac12_pkg::*;
#(
  parameter int HW         = 4,
  parameter int MW         = 6,
  parameter int HR_MAX     = 11,
  parameter int MN_MAX     = 59,
  parameter int ALARM_SECS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          hr_inc,
  input  logic          mn_inc,
  input  logic          pm_in,
  input  logic          strobe,
  input  logic [HW-1:0] t_hr,
  input  logic [MW-1:0] t_mn,
  input  logic [MW-1:0] t_sc,
  input  logic          t_pm,
  output logic [HW-1:0] a_hr,
  output logic [MW-1:0] a_mn,
  output logic          a_pm,
  output logic          alarm
);

  localparam int CW = $clog2(ALARM_SECS + 1);

  logic [HW-1:0] ahr_q, ahr_d;
  logic [MW-1:0] amn_q, amn_d;
  logic          apm_q, apm_d;
  logic          al_q, al_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          hit;

  assign hit = strobe && (t_sc == '0) && (t_hr == ahr_q) && (t_mn == amn_q) && (t_pm == apm_q);

  always_comb begin
    ahr_d = ahr_q;
    amn_d = amn_q;
    apm_d = apm_q;
    if (set_en) begin
      if (hr_inc) ahr_d = HW'(wrap_inc(6'(ahr_q), 6'(HR_MAX)));
      if (mn_inc) amn_d = MW'(wrap_inc(6'(amn_q), 6'(MN_MAX)));
      apm_d = pm_in;
    end
  end

  always_comb begin
    al_d  = al_q;
    rem_d = rem_q;
    if (hit) begin
      al_d  = 1'b1;
      rem_d = CW'(ALARM_SECS);
    end else if (strobe && al_q) begin
      rem_d = rem_q - CW'(1);
      al_d  = (rem_q != CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahr_q <= '0;
      amn_q <= '0;
      apm_q <= 1'b0;
      al_q  <= 1'b0;
      rem_q <= '0;
    end else begin
      ahr_q <= ahr_d;
      amn_q <= amn_d;
      apm_q <= apm_d;
      al_q  <= al_d;
      rem_q <= rem_d;
    end
  end

  assign a_hr  = ahr_q;
  assign a_mn  = amn_q;
  assign a_pm  = apm_q;
  assign alarm = al_q;

  a_r7_rise_on_second_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_q) |-> ($past(strobe) && $past(t_sc) == '0));

  a_r8_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(al_q) |-> $past(strobe));

  a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (al_q && !strobe) |=> al_q);

  a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    al_q |-> (rem_q != '0));

endmodule

// File: rtl/alarm_clock12_core.sv
module alarm_clock12_core
  import ac12_pkg::*;
#(
  parameter int ALARM_SECS = 10,
  parameter int HR_MAX     = 11,
  parameter int MN_MAX     = 59,
  parameter int SC_MAX     = 59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       hr_btn_n,
  input  logic       mn_btn_n,
  input  logic       ampm_sel,
  input  logic       start,
  output logic [1:0] phase,
  output logic [7:0] hr_bcd,
  output logic [7:0] mn_bcd,
  output logic [7:0] sc_bcd,
  output logic       pm_flag,
  output logic       alarm_out
);

  localparam int HW = $clog2(HR_MAX + 1);
  localparam int MW = 6;

  // reset: asserted at once, released on the clock
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  // button and start edges: bit0 hour, bit1 minute, bit2 start
  logic [2:0] ev;
  ac12_sync_edge #(.W(3), .IDLE(3'b011), .ACT_LOW(3'b011)) u_edges (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   ({start, mn_btn_n, hr_btn_n}),
    .pulse (ev)
  );

  phase_e ph_q, ph_d;
  always_comb begin
    ph_d = ph_q;
    if (ev[2]) begin
      case (ph_q)
        PH_ALARM: ph_d = PH_TIME;
        PH_TIME:  ph_d = PH_RUN;
        default:  ph_d = ph_q;
      endcase
    end
  end

  logic run, strobe_q;
  assign run = (ph_q == PH_RUN);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ph_q     <= PH_ALARM;
      strobe_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      strobe_q <= sec_tick & run;
    end
  end

  logic [HW-1:0] t_hr, a_hr;
  logic [MW-1:0] t_mn, t_sc, a_mn;
  logic          t_pm, a_pm;

  ac12_timekeeper #(.HW(HW), .MW(MW), .HR_MAX(HR_MAX), .MN_MAX(MN_MAX), .SC_MAX(SC_MAX)) u_time (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run    (run),
    .set_en (ph_q == PH_TIME),
    .tick   (sec_tick),
    .hr_inc (ev[0]),
    .mn_inc (ev[1]),
    .pm_in  (ampm_sel),
    .hr     (t_hr),
    .mn     (t_mn),
    .sc     (t_sc),
    .pm     (t_pm)
  );

  ac12_alarm_unit #(.HW(HW), .MW(MW), .HR_MAX(HR_MAX), .MN_MAX(MN_MAX), .ALARM_SECS(ALARM_SECS)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_en (ph_q == PH_ALARM),
    .hr_inc (ev[0]),
    .mn_inc (ev[1]),
    .pm_in  (ampm_sel),
    .strobe (strobe_q),
    .t_hr   (t_hr),
    .t_mn   (t_mn),
    .t_sc   (t_sc),
    .t_pm   (t_pm),
    .a_hr   (a_hr),
    .a_mn   (a_mn),
    .a_pm   (a_pm),
    .alarm  (alarm_out)
  );

  // display selection
  logic show_alarm;
  assign show_alarm = (ph_q == PH_ALARM);
  assign phase   = ph_q;
  assign hr_bcd  = bin2bcd(6'(show_alarm ? a_hr : t_hr));
  assign mn_bcd  = bin2bcd(show_alarm ? a_mn : t_mn);
  assign sc_bcd  = bin2bcd(show_alarm ? 6'd0 : t_sc);
  assign pm_flag = show_alarm ? a_pm : t_pm;

  a_r3_run_is_final: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ph_q == PH_RUN) |=> (ph_q == PH_RUN));

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_i_n)
    ph_q != 2'd3);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ph_q != $past(ph_q)) |-> (int'(ph_q) == int'($past(ph_q)) + 1));

endmodule

// File: tb/alarm_clock12_core_tb.sv
module alarm_clock12_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSECS      = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       hr_btn_n = 1'b1;
  logic       mn_btn_n = 1'b1;
  logic       ampm_sel = 1'b0;
  logic       start = 1'b0;
  logic [1:0] phase;
  logic [7:0] hr_bcd, mn_bcd, sc_bcd;
  logic       pm_flag, alarm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_clock12_core #(.ALARM_SECS(NSECS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hr_btn_n(hr_btn_n),
    .mn_btn_n(mn_btn_n), .ampm_sel(ampm_sel), .start(start), .phase(phase),
    .hr_bcd(hr_bcd), .mn_bcd(mn_bcd), .sc_bcd(sc_bcd), .pm_flag(pm_flag),
    .alarm_out(alarm_out)
  );

  // behavioural model state
  int m_ph, m_th, m_tm, m_ts, m_tp, m_ah, m_am, m_ap, m_al, m_rem, m_str;
  bit hb[3], mb[3], sb[3];

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_th = 0; m_tm = 0; m_ts = 0; m_tp = 0;
      m_ah = 0; m_am = 0; m_ap = 0; m_al = 0; m_rem = 0; m_str = 0;
      for (int i = 0; i < 3; i++) begin hb[i] = 1; mb[i] = 1; sb[i] = 0; end
    end else begin
      bit hp, mp, sp;
      int old_str;
      hp = (hb[1] == 0) && (hb[2] == 1);
      mp = (mb[1] == 0) && (mb[2] == 1);
      sp = (sb[1] == 1) && (sb[2] == 0);
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = hr_btn_n;
      mb[2] = mb[1]; mb[1] = mb[0]; mb[0] = mn_btn_n;
      sb[2] = sb[1]; sb[1] = sb[0]; sb[0] = start;
      old_str = m_str;
      m_str = (sec_tick && m_ph == 2) ? 1 : 0;
      // R7 / R8: match at second zero, then a fixed count of seconds
      if (old_str == 1 && m_ts == 0 && m_th == m_ah && m_tm == m_am && m_tp == m_ap) begin
        m_al = 1; m_rem = NSECS;
      end else if (old_str == 1 && m_al == 1) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_al = 0;
      end
      if (m_ph == 0) begin
        if (hp) m_ah = (m_ah + 1) % 12;
        if (mp) m_am = (m_am + 1) % 60;
        m_ap = ampm_sel;
      end else if (m_ph == 1) begin
        if (hp) m_th = (m_th + 1) % 12;
        if (mp) m_tm = (m_tm + 1) % 60;
        m_tp = ampm_sel;
      end else if (sec_tick) begin
        m_ts = m_ts + 1;
        if (m_ts == 60) begin
          m_ts = 0; m_tm = m_tm + 1;
          if (m_tm == 60) begin
            m_tm = 0; m_th = m_th + 1;
            if (m_th == 12) begin m_th = 0; m_tp = 1 - m_tp; end
          end
        end
      end
      if (sp && m_ph < 2) m_ph = m_ph + 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      logic [7:0] eh, em, es;
      int ep;
      bad = 0;
      eh = (m_ph == 0) ? bcd(m_ah) : bcd(m_th);
      em = (m_ph == 0) ? bcd(m_am) : bcd(m_tm);
      es = (m_ph == 0) ? bcd(0)    : bcd(m_ts);
      ep = (m_ph == 0) ? m_ap : m_tp;
      n_cmp++;
      if (int'(phase) != m_ph) begin
        bad = 1; $display("FAIL R3 phase: got %0d expected %0d at %0t", phase, m_ph, $time);
      end
      if (hr_bcd !== eh) begin
        bad = 1; $display("FAIL R2/R9 hour: got %h expected %h at %0t", hr_bcd, eh, $time);
      end
      if (mn_bcd !== em) begin
        bad = 1; $display("FAIL R1/R4 minute: got %h expected %h at %0t", mn_bcd, em, $time);
      end
      if (sc_bcd !== es) begin
        bad = 1; $display("FAIL R1/R6 second: got %h expected %h at %0t", sc_bcd, es, $time);
      end
      if (int'(pm_flag) != ep) begin
        bad = 1; $display("FAIL R5 pm_flag: got %0d expected %0d at %0t", pm_flag, ep, $time);
      end
      if (int'(alarm_out) != m_al) begin
        bad = 1; $display("FAIL R7/R8 alarm_out: got %0d expected %0d at %0t", alarm_out, m_al, $time);
      end
      if (bad) n_bad++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit which_min, input int hold);
    @(negedge clk);
    if (which_min) mn_btn_n = 1'b0; else hr_btn_n = 1'b0;
    idle(hold);
    hr_btn_n = 1'b1; mn_btn_n = 1'b1;
    idle(4);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    idle(4);
    start = 1'b0;
    idle(4);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      idle(2);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    // R3 / R9: reset state shown at the ports
    n_cmp++;
    if (phase !== 2'd0 || hr_bcd !== 8'h00 || mn_bcd !== 8'h00 || sc_bcd !== 8'h00 ||
        pm_flag !== 1'b0 || alarm_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R3 reset: got %0d %h:%h:%h pm%0d al%0d expected 0 00:00:00 pm0 al0",
               phase, hr_bcd, mn_bcd, sc_bcd, pm_flag, alarm_out);
    end
    // R6: ticks before run do nothing
    ticks(5);
    // R4: long hold gives one step, then wrap 11 -> 0 on the alarm hour
    ampm_sel = 1'b1;                       // R5: alarm in the afternoon
    press(1'b0, 25);
    for (int i = 0; i < 11; i++) press(1'b0, 2);
    press(1'b1, 3);                        // alarm minute 1 ...
    for (int i = 0; i < 59; i++) press(1'b1, 2);   // ... wraps back to 0
    pulse_start();                         // R3: to time entry
    ampm_sel = 1'b0;
    ticks(3);                              // R6: still ignored
    for (int i = 0; i < 11; i++) press(1'b0, 2);   // time hour 11
    for (int i = 0; i < 119; i++) press(1'b1, 2);  // R4: minute wraps, ends at 59
    pulse_start();                         // R3: to run
    // R5: buttons, switch and start ignored in run
    ampm_sel = 1'b1;
    press(1'b0, 3);
    press(1'b1, 3);
    pulse_start();
    ampm_sel = 1'b0;
    // R1 / R2 / R7: 11:59:00 AM to 00:00:00 PM matches the alarm
    ticks(60);
    // R8: alarm length, then an hour and more of run time
    ticks(NSECS + 3);
    ticks(3700);
    idle(5);
    finish_run();
  end

endmodule